// File: doc/BRIEF.md
# Multi-Mode PWM Timer Channel

This block is one pulse-width-modulation channel built around a prescaled timer counter. A clock divider produces a counting tick once every `psc_val + 1` clocks. On each tick the counter steps according to one of three counting schemes: edge-aligned up-counting, edge-aligned down-counting, or center-aligned counting that climbs to the reload value and falls back. A compare stage asserts the channel while the counter sits below the compare value. Polarity is selectable. The waveform can be steered to a complementary pin that has its own polarity control.

The reload (period) and compare values arrive on shadow inputs. They reach the active registers only at an update point: the counter wrap in up mode, the underflow in down mode, or the bottom turnaround in center mode. A one-cycle software update strobe also loads them. The strobe captures the shadow values and the counting scheme, restarts the divider and the counter, and so guarantees a clean first period. An update-event pulse marks every wrap, every underflow, both center turnarounds and each software update.

The counter is a four-state machine. `ST_UP` counts up and wraps to 0 after the reload value. `ST_DOWN` counts down and reloads at 0. `ST_RISE` and `ST_FALL` are the two halves of center-aligned counting: RISE goes to FALL at the reload value, and FALL goes to RISE at 0. The software update enters `ST_UP`, `ST_DOWN` or `ST_RISE` from any state, depending on the mode code. Reset enters `ST_UP`.

Top module: `pwm_tmr_chan`

## Requirements
- R1: While reset is held, `upd_evt` is 0 and the outputs are at their inactive levels: `pwm_main` equals `pol_low` and `pwm_comp` equals `comp_pol_low`. The counter, the active reload value and the active compare value are all 0.
- R2: Mode code 0 counts up. The counter runs 0, 1, …, R and then returns to 0, where R is the active reload value. A period is therefore R+1 ticks, and the counter never exceeds R.
- R3: The counter steps once every `psc_val`+1 clocks and holds in between. The software update restarts the divider, so the first step comes `psc_val`+1 clocks after the strobe.
- R4: Mode code 1 counts down. After a software update the counter holds R. It counts down to 0 and then reloads R, so a period is R+1 ticks.
- R5: Mode code 2 is center-aligned. The counter runs 0 up to R and back down to 0, so a period is 2·R ticks. With R = 0 the counter stays at 0.
- R6: The channel is active while the counter is below the active compare value C. With C = 0 it is never active. With C > R it is active for the whole period.
- R7: With `pol_low` = 1, `pwm_main` is inverted: low while active, high while inactive.
- R8: With `comp_en` = 1, `pwm_main` holds its inactive level and `pwm_comp` carries the waveform XOR `comp_pol_low`. With `comp_en` = 0, `pwm_comp` holds `comp_pol_low`.
- R9: The shadow inputs are copied into the active registers only at a wrap (mode 0), an underflow (mode 1), a bottom turnaround (mode 2) or a software update. A shadow change in between has no effect until that point.
- R10: A `sw_upd` pulse does the following at that edge: it loads both shadows, takes `mode_sel`, restarts the counter (to 0, or to R in mode 1) and the divider, and raises `upd_evt` in the next cycle. `mode_sel` has no effect at any other time. Code 3 behaves as code 0.
- R11: With `CNT_W` = 16 and R = 65535, the up-counting period is 65536 ticks.
- R12: `upd_evt` is high for exactly the one clock that follows each counter wrap, underflow, center turnaround (top and bottom) or software update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psc_val | input | PSC_W | Divider value; counter steps every psc_val+1 clocks |
| mode_sel | input | 2 | Counting scheme: 0 up, 1 down, 2 center, 3 up; taken at sw_upd |
| arr_shadow | input | CNT_W | Reload (period) shadow value |
| cmp_shadow | input | CNT_W | Compare shadow value |
| pol_low | input | 1 | 1 makes pwm_main active-low |
| comp_en | input | 1 | 1 routes the waveform to pwm_comp instead of pwm_main |
| comp_pol_low | input | 1 | 1 makes pwm_comp active-low |
| sw_upd | input | 1 | Software update strobe: loads shadows, restarts counting |
| pwm_main | output | 1 | Main PWM output |
| pwm_comp | output | 1 | Complementary PWM output |
| upd_evt | output | 1 | One-clock update-event pulse |

## Verification
The clock edge that samples `sw_upd` produces cycle 0 of a run. In cycle 0 the counter holds its start value and `upd_evt` is high. From then on, the counter changes only at edges that end a cycle whose index k satisfies k mod (`psc_val`+1) = `psc_val`. Both PWM pins follow the counter and the polarity inputs combinationally, in the same cycle. `upd_evt` is registered and appears in the first cycle of the step that follows a wrap or turnaround. After each edge, the driver pushes the expected pin triple for that cycle. The monitor pops and compares it on the following falling edge. Input changes happen one nanosecond after a rising edge, and never in a cycle that is being compared.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    typedef enum logic [1:0] {
        ST_UP   = 2'd0,
        ST_DOWN = 2'd1,
        ST_RISE = 2'd2,
        ST_FALL = 2'd3
    } cnt_state_e;

    localparam logic [1:0] MODE_UP   = 2'd0;
    localparam logic [1:0] MODE_DOWN = 2'd1;
    localparam logic [1:0] MODE_CTR  = 2'd2;

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc_val,
    output logic             tick
);

    logic [PSC_W-1:0] div_q;

    // >= keeps the divider from running past a freshly lowered limit
    assign tick = (div_q >= psc_val);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_cnt_fsm.sv
module pwm_cnt_fsm
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sw_upd,
    input  logic [1:0]       mode_sel,
    input  logic [CNT_W-1:0] arr_shadow,
    input  logic [CNT_W-1:0] cmp_shadow,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] arr_act,
    output logic [CNT_W-1:0] cmp_act,
    output logic             load,
    output logic             upd_evt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] arr_q, cmp_q;
    logic             wrap;
    logic             evt_q;

    // next state, next count, wrap and shadow-load decisions
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        wrap  = 1'b0;
        load  = 1'b0;
        if (sw_upd) begin
            wrap = 1'b1;
            load = 1'b1;
            case (mode_sel)
                MODE_DOWN: begin
                    st_d  = ST_DOWN;
                    cnt_d = arr_shadow;
                end
                MODE_CTR: begin
                    st_d  = ST_RISE;
                    cnt_d = '0;
                end
                default: begin
                    st_d  = ST_UP;
                    cnt_d = '0;
                end
            endcase
        end else if (tick) begin
            unique case (st_q)
                ST_UP: begin
                    if (cnt_q >= arr_q) begin
                        cnt_d = '0;
                        wrap  = 1'b1;
                        load  = 1'b1;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                ST_DOWN: begin
                    if (cnt_q == '0) begin
                        cnt_d = arr_shadow;
                        wrap  = 1'b1;
                        load  = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                ST_RISE: begin
                    if (cnt_q >= arr_q) begin
                        st_d  = ST_FALL;
                        wrap  = 1'b1;
                        cnt_d = (cnt_q == '0) ? '0 : cnt_q - ONE;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                ST_FALL: begin
                    if (cnt_q == '0) begin
                        st_d  = ST_RISE;
                        wrap  = 1'b1;
                        load  = 1'b1;
                        cnt_d = (arr_shadow == '0) ? '0 : ONE;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            endcase
        end
    end

    // state register and active copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_UP;
            cnt_q <= '0;
            arr_q <= '0;
            cmp_q <= '0;
            evt_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            evt_q <= wrap;
            if (load) begin
                arr_q <= arr_shadow;
                cmp_q <= cmp_shadow;
            end
        end
    end

    assign cnt     = cnt_q;
    assign arr_act = arr_q;
    assign cmp_act = cmp_q;
    assign upd_evt = evt_q;

endmodule

// File: rtl/pwm_cmp_out.sv
module pwm_cmp_out #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_act,
    input  logic             pol_low,
    input  logic             comp_en,
    input  logic             comp_pol_low,
    output logic             pwm_main,
    output logic             pwm_comp
);

    logic active;

    always_comb begin
        active   = (cnt < cmp_act);
        pwm_main = comp_en ? pol_low : (active ^ pol_low);
        pwm_comp = comp_en ? (active ^ comp_pol_low) : comp_pol_low;
    end

endmodule

// File: rtl/pwm_tmr_chan.sv
module pwm_tmr_chan #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] psc_val,
    input  logic [1:0]       mode_sel,
    input  logic [CNT_W-1:0] arr_shadow,
    input  logic [CNT_W-1:0] cmp_shadow,
    input  logic             pol_low,
    input  logic             comp_en,
    input  logic             comp_pol_low,
    input  logic             sw_upd,
    output logic             pwm_main,
    output logic             pwm_comp,
    output logic             upd_evt
);

    logic             tick_w;
    logic             load_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] arr_w;
    logic [CNT_W-1:0] cmp_w;

    pwm_tick_gen #(.PSC_W(PSC_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (sw_upd),
        .psc_val (psc_val),
        .tick    (tick_w)
    );

    pwm_cnt_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_w),
        .sw_upd     (sw_upd),
        .mode_sel   (mode_sel),
        .arr_shadow (arr_shadow),
        .cmp_shadow (cmp_shadow),
        .cnt        (cnt_w),
        .arr_act    (arr_w),
        .cmp_act    (cmp_w),
        .load       (load_w),
        .upd_evt    (upd_evt)
    );

    pwm_cmp_out #(.CNT_W(CNT_W)) u_out (
        .cnt          (cnt_w),
        .cmp_act      (cmp_w),
        .pol_low      (pol_low),
        .comp_en      (comp_en),
        .comp_pol_low (comp_pol_low),
        .pwm_main     (pwm_main),
        .pwm_comp     (pwm_comp)
    );

endmodule

// File: rtl/pwm_tmr_chan_chk.sv
module pwm_tmr_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             sw_upd,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] arr_act,
    input logic [CNT_W-1:0] cmp_act,
    input logic             pol_low,
    input logic             comp_en,
    input logic             pwm_main,
    input logic             upd_evt
);

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= arr_act);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !sw_upd) |=> $stable(cnt));

    p_sw_evt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_upd |=> upd_evt);

    p_load_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(arr_act) || !$stable(cmp_act)) |-> upd_evt);

    p_zero_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_act == '0 && !comp_en && !pol_low) |-> !pwm_main);

endmodule

bind pwm_tmr_chan pwm_tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_w),
    .sw_upd   (sw_upd),
    .cnt      (cnt_w),
    .arr_act  (arr_w),
    .cmp_act  (cmp_w),
    .pol_low  (pol_low),
    .comp_en  (comp_en),
    .pwm_main (pwm_main),
    .upd_evt  (upd_evt)
);

// File: tb/pwm_tmr_chan_test.sv
`timescale 1ns/1ps
module pwm_tmr_chan_test;

    localparam int CNT_W = 16;
    localparam int PSC_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PSC_W-1:0] psc_val = '0;
    logic [1:0]       mode_sel = 2'd0;
    logic [CNT_W-1:0] arr_shadow = '0;
    logic [CNT_W-1:0] cmp_shadow = '0;
    logic             pol_low = 1'b0;
    logic             comp_en = 1'b0;
    logic             comp_pol_low = 1'b0;
    logic             sw_upd = 1'b0;
    logic             pwm_main, pwm_comp, upd_evt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [2:0] q_val[$];
    string      q_tag[$];
    logic [2:0] mon_exp;
    logic [2:0] mon_act;
    string      mon_tag;

    always #2 clk = ~clk;

    pwm_tmr_chan #(.CNT_W(CNT_W), .PSC_W(PSC_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .psc_val      (psc_val),
        .mode_sel     (mode_sel),
        .arr_shadow   (arr_shadow),
        .cmp_shadow   (cmp_shadow),
        .pol_low      (pol_low),
        .comp_en      (comp_en),
        .comp_pol_low (comp_pol_low),
        .sw_upd       (sw_upd),
        .pwm_main     (pwm_main),
        .pwm_comp     (pwm_comp),
        .upd_evt      (upd_evt)
    );

    // expected {main, comp, evt} in cycle k after a software update
    function automatic logic [2:0] exp_at(int md, int ps, int ar, int cm,
                                          bit pl, bit ce, bit cp, int k);
        int t;
        int c;
        int pos;
        bit first;
        bit ev;
        bit act;
        t     = k / (ps + 1);
        first = ((k % (ps + 1)) == 0);
        if (md == 1) begin
            c  = ar - (t % (ar + 1));
            ev = ((t % (ar + 1)) == 0);
        end else if (md == 2) begin
            if (ar == 0) begin
                c  = 0;
                ev = 1'b1;
            end else begin
                pos = t % (2 * ar);
                c   = (pos <= ar) ? pos : (2 * ar - pos);
                ev  = (t == 0) || (t >= 2 && ((t - 1) % ar) == 0);
            end
        end else begin
            c  = t % (ar + 1);
            ev = ((t % (ar + 1)) == 0);
        end
        ev  = ev && first;
        act = (c < cm);
        return {ce ? pl : (act ^ pl), ce ? (act ^ cp) : cp, ev};
    endfunction

    // driver: starts a run with a software update and queues expectations
    task automatic run_case(input int md, input int ps, input int ar, input int cm,
                            input bit pl, input bit ce, input bit cp,
                            input int ncyc, input int new_ar, input int new_cm,
                            input string tag);
        int sw_at;
        sw_at        = (ar + 1) * (ps + 1);
        mode_sel     = md[1:0];
        psc_val      = ps[PSC_W-1:0];
        arr_shadow   = ar[CNT_W-1:0];
        cmp_shadow   = cm[CNT_W-1:0];
        pol_low      = pl;
        comp_en      = ce;
        comp_pol_low = cp;
        sw_upd       = 1'b1;
        @(posedge clk);
        for (int k = 0; k < ncyc; k++) begin
            #1;
            if (k == 0) sw_upd = 1'b0;
            if (k == 1 && new_ar >= 0) begin
                arr_shadow = new_ar[CNT_W-1:0];
                cmp_shadow = new_cm[CNT_W-1:0];
            end
            if (new_ar >= 0 && k >= sw_at)
                q_val.push_back(exp_at(md, ps, new_ar, new_cm, pl, ce, cp, k - sw_at));
            else
                q_val.push_back(exp_at(md, ps, ar, cm, pl, ce, cp, k));
            q_tag.push_back(tag);
            @(posedge clk);
        end
        #1;
    endtask

    // monitor: compares one queued expectation per falling edge
    always @(negedge clk) begin
        if (q_val.size() > 0) begin
            mon_exp = q_val.pop_front();
            mon_tag = q_tag.pop_front();
            mon_act = {pwm_main, pwm_comp, upd_evt};
            n_chk++;
            if (mon_act !== mon_exp) begin
                n_fail++;
                $display("FAIL %s: {main,comp,evt} actual %b expected %b",
                         mon_tag, mon_act, mon_exp);
            end
        end
    end

    task automatic chk_bit(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_bit(upd_evt, 1'b0, "R1 upd_evt in reset");
        chk_bit(pwm_main, 1'b0, "R1 pwm_main in reset");
        chk_bit(pwm_comp, 1'b0, "R1 pwm_comp in reset");
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R2 R12 up counting
        run_case(0, 0, 4, 2, 0, 0, 0, 30, -1, 0, "R2 R12 up");
        // R3 prescaler
        run_case(0, 2, 3, 1, 0, 0, 0, 40, -1, 0, "R3 prescale");
        // R4 down counting
        run_case(1, 0, 5, 3, 0, 0, 0, 30, -1, 0, "R4 R12 down");
        // R5 center aligned
        run_case(2, 0, 4, 2, 0, 0, 0, 30, -1, 0, "R5 R12 center");
        run_case(2, 1, 3, 3, 0, 0, 0, 30, -1, 0, "R5 center prescaled");
        run_case(2, 0, 0, 1, 0, 0, 0, 8, -1, 0, "R5 center zero reload");
        // R6 compare boundaries
        run_case(0, 0, 3, 0, 0, 0, 0, 12, -1, 0, "R6 compare zero");
        run_case(0, 0, 3, 9, 0, 0, 0, 12, -1, 0, "R6 compare above reload");
        // R7 polarity
        run_case(0, 0, 4, 2, 1, 0, 0, 15, -1, 0, "R7 active low");
        // R8 complementary output
        run_case(0, 0, 4, 3, 0, 1, 0, 15, -1, 0, "R8 comp high");
        run_case(1, 0, 4, 3, 1, 1, 1, 15, -1, 0, "R8 comp low");
        // R9 shadow values wait for the wrap
        run_case(0, 0, 4, 2, 0, 0, 0, 20, 2, 1, "R9 shadow transfer");
        // R10 restart mid-period with mode code 3 acting as up
        run_case(3, 1, 6, 4, 0, 0, 0, 20, -1, 0, "R10 restart code3");
        // R11 full 16-bit period
        run_case(0, 0, 65535, 32768, 0, 0, 0, 65540, -1, 0, "R11 full period");

        wait (q_val.size() == 0);
        @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule